// File: doc/BRIEF.md
# Head-of-Line Retry Queue Arbiter

This block keeps track of the ports on a shared bus whose transfers were turned away, and decides which of them gets the next chance to resend. Refused ports wait in a first-in first-out queue of port numbers, and each port can appear in it only once. Each time the bus goes free, the port at the front of the queue is offered the bus for exactly one cycle. How that port answers decides whether it leaves the queue.

The control is a two-state machine. **IDLE** means no offer is outstanding. **OFFER** means a one-hot grant is driven to the captured front port. It has these transitions:

- **IDLE→OFFER** (`take_head`): the bus goes free while the queue is not empty.
- **OFFER→IDLE** (`resolve`): always taken after one cycle. Depending on what the granted port did, it pops the front entry (the port succeeded, or it went silent) or keeps it (the port was refused again).
- **IDLE→IDLE** (`hold`): enqueues refused ports and otherwise waits.

A send that is reported as completed by a snooping peer counts as a success. Three sticky flags report events: a granted port that stayed silent, a send from a port that was not granted during an offer, and a refused port that found the queue full. Only reset clears these flags.

Top module: `retry_queue_arb`

## Requirements
- R1: After reset no grant is driven, `retry_active` is 0, `retry_port` is 0, all three sticky flags are 0, and the queue is empty.
- R2: In IDLE, a send with `send_ok`=0 and `send_peer_done`=0 from a port not already queued is appended at the tail. Grants are later issued in arrival order.
- R3: In IDLE, `bus_free` with a non-empty queue moves the block to OFFER after the edge. There, `retry_gnt` has exactly bit `p` set, where `p` is the front port, `retry_active` is 1 and `retry_port` is `p`. The offer lasts exactly one cycle.
- R4: In OFFER, a send from the granted port with `send_ok`=1 pops the front entry and returns to IDLE.
- R5: In OFFER, a send from the granted port with `send_ok`=0 and `send_peer_done`=0 returns to IDLE and leaves that port at the front. The next `bus_free` grants the same port again.
- R6: In OFFER, if the granted port does not send, the front entry is dropped and `warn_silent` is set and stays set until reset.
- R7: In OFFER, a send from any other port sets `err_foreign`, which stays set until reset. That port is never enqueued by that send.
- R8: `send_peer_done`=1 marks a send as completed by a snooping peer. From the granted port in OFFER it pops the front entry. In IDLE it never enqueues the sender.
- R9: A refused port that is already in the queue is not added a second time.
- R10: A refused new port that finds all DEPTH entries in use is dropped, and `overflow` is set and stays set until reset.
- R11: `bus_free` is ignored in OFFER, and it is ignored in IDLE when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_valid | input | 1 | A port attempts a send this cycle |
| send_port | input | ID_W | Number of the sending port |
| send_ok | input | 1 | The attempted send was accepted |
| send_peer_done | input | 1 | The send was completed by a snooping peer |
| bus_free | input | 1 | The bus became free this cycle |
| retry_gnt | output | NUM_PORTS | One-hot retry grant, bit i for port i |
| retry_active | output | 1 | An offer is outstanding (state OFFER) |
| retry_port | output | ID_W | Port currently offered, 0 when idle |
| warn_silent | output | 1 | Sticky: a granted port did not respond |
| err_foreign | output | 1 | Sticky: a port that was not granted sent during an offer |
| overflow | output | 1 | Sticky: a refused port was dropped because the queue was full |

## Verification
Several directed sequences exercise each way an offer can resolve: success, refusal again, peer completion, silence and a foreign sender. Each one is followed by a further `bus_free` so that the next grant shows whether the front entry was kept or dropped. Further patterns fill the queue past DEPTH and repeat a refusal from a port already queued, which separates deduplication from overflow. Other patterns assert `bus_free` while empty or during an offer, which shows that those edges are ignored. A long seeded random run then mixes all of these against a queue model in the bench, with periodic resets. Tail ordering is judged by the order in which grants appear.

// File: rtl/rq_pkg.sv
package rq_pkg;
    typedef enum logic [0:0] {
        RQ_IDLE  = 1'b0,
        RQ_OFFER = 1'b1
    } rq_state_e;
endpackage

// File: rtl/rq_fifo.sv
module rq_fifo #(
    parameter int NUM_PORTS = 8,
    parameter int DEPTH     = 4,
    parameter int ID_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [ID_W-1:0]      push_id,
    input  logic                 pop,
    output logic [ID_W-1:0]      head_id,
    output logic                 empty,
    output logic                 full,
    output logic [NUM_PORTS-1:0] member
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ID_W-1:0]      slot_q [DEPTH];
    logic [PTR_W-1:0]     rd_q, wr_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [NUM_PORTS-1:0] member_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            rd_q     <= '0;
            wr_q     <= '0;
            cnt_q    <= '0;
            member_q <= '0;
        end else begin
            if (push) begin
                slot_q[wr_q]      <= push_id;
                wr_q              <= ptr_inc(wr_q);
                member_q[push_id] <= 1'b1;
            end
            if (pop) begin
                rd_q                   <= ptr_inc(rd_q);
                member_q[slot_q[rd_q]] <= 1'b0;
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_id = slot_q[rd_q];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign member  = member_q;
endmodule

// File: rtl/rq_onehot.sv
module rq_onehot #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] vec
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign vec[g] = en && (idx == W'(g));
    end
endmodule

// File: rtl/retry_queue_arb.sv
module retry_queue_arb #(
    parameter int NUM_PORTS = 8,
    parameter int DEPTH     = 4
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              send_valid,
    input  logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] send_port,
    input  logic                                              send_ok,
    input  logic                                              send_peer_done,
    input  logic                                              bus_free,
    output logic [NUM_PORTS-1:0]                              retry_gnt,
    output logic                                              retry_active,
    output logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] retry_port,
    output logic                                              warn_silent,
    output logic                                              err_foreign,
    output logic                                              overflow
);
    import rq_pkg::*;

    localparam int ID_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    rq_state_e            state_q, state_d;
    logic [ID_W-1:0]      rport_q;
    logic                 load_head;
    logic                 push, pop;
    logic                 ovf_set, warn_set, err_set;
    logic [ID_W-1:0]      head_id;
    logic                 q_empty, q_full;
    logic [NUM_PORTS-1:0] q_member;
    logic                 own_send, refused, done_ok;
    logic                 offer_on;

    assign own_send = send_valid && (send_port == rport_q);
    assign refused  = send_valid && !send_ok && !send_peer_done;
    assign done_ok  = send_ok || send_peer_done;

    rq_fifo #(
        .NUM_PORTS (NUM_PORTS),
        .DEPTH     (DEPTH),
        .ID_W      (ID_W)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .push_id (send_port),
        .pop     (pop),
        .head_id (head_id),
        .empty   (q_empty),
        .full    (q_full),
        .member  (q_member)
    );

    // Next-state and queue control
    always_comb begin
        state_d   = state_q;
        load_head = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        ovf_set   = 1'b0;
        warn_set  = 1'b0;
        err_set   = 1'b0;
        unique case (state_q)
            RQ_IDLE: begin
                if (refused && !q_member[send_port]) begin
                    if (q_full) ovf_set = 1'b1;
                    else        push    = 1'b1;
                end
                if (bus_free && !q_empty) begin
                    state_d   = RQ_OFFER;
                    load_head = 1'b1;
                end
            end
            RQ_OFFER: begin
                state_d = RQ_IDLE;
                if (own_send) begin
                    pop = done_ok;
                end else begin
                    pop      = 1'b1;
                    warn_set = 1'b1;
                    err_set  = send_valid;
                end
            end
            default: state_d = RQ_IDLE;
        endcase
    end

    // State register and captured retrying port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
            rport_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_head) rport_q <= head_id;
        end
    end

    // Sticky status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_silent <= 1'b0;
            err_foreign <= 1'b0;
            overflow    <= 1'b0;
        end else begin
            if (warn_set) warn_silent <= 1'b1;
            if (err_set)  err_foreign <= 1'b1;
            if (ovf_set)  overflow    <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        offer_on     = (state_q == RQ_OFFER);
        retry_active = offer_on;
        retry_port   = offer_on ? rport_q : '0;
    end

    rq_onehot #(
        .N (NUM_PORTS),
        .W (ID_W)
    ) u_gnt (
        .en  (offer_on),
        .idx (rport_q),
        .vec (retry_gnt)
    );
endmodule

// File: rtl/rq_checker.sv
module rq_checker #(
    parameter int NUM_PORTS = 8,
    parameter int ID_W      = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_free,
    input logic [NUM_PORTS-1:0] retry_gnt,
    input logic                 retry_active,
    input logic [ID_W-1:0]      retry_port,
    input logic                 warn_silent,
    input logic                 err_foreign,
    input logic                 overflow
);
    a_r3_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(retry_gnt));

    a_r3_gnt_matches_port: assert property (@(posedge clk) disable iff (!rst_n)
        retry_active |-> (retry_gnt[retry_port] && $countones(retry_gnt) == 1));

    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        retry_active |=> !retry_active);

    a_r3_needs_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_active) |-> $past(bus_free));

    a_r6_warn_after_offer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_silent) |-> $past(retry_active));

    a_r6_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        warn_silent |=> warn_silent);

    a_r7_err_after_offer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_foreign) |-> $past(retry_active));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_foreign |=> err_foreign);

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind retry_queue_arb rq_checker #(
    .NUM_PORTS (NUM_PORTS),
    .ID_W      (ID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_free     (bus_free),
    .retry_gnt    (retry_gnt),
    .retry_active (retry_active),
    .retry_port   (retry_port),
    .warn_silent  (warn_silent),
    .err_foreign  (err_foreign),
    .overflow     (overflow)
);

// File: tb/retry_queue_arb_tb.sv
module retry_queue_arb_tb;
    localparam int NP = 8;
    localparam int DP = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          send_valid = 1'b0;
    logic [IW-1:0] send_port = '0;
    logic          send_ok = 1'b0;
    logic          send_peer_done = 1'b0;
    logic          bus_free = 1'b0;
    logic [NP-1:0] retry_gnt;
    logic          retry_active;
    logic [IW-1:0] retry_port;
    logic          warn_silent, err_foreign, overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Queue model
    int mq [DP];
    int mn;
    bit m_offer;
    int m_rport;
    bit m_warn, m_err, m_ovf;

    always #5 clk = ~clk;

    retry_queue_arb #(.NUM_PORTS(NP), .DEPTH(DP)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .send_valid     (send_valid),
        .send_port      (send_port),
        .send_ok        (send_ok),
        .send_peer_done (send_peer_done),
        .bus_free       (bus_free),
        .retry_gnt      (retry_gnt),
        .retry_active   (retry_active),
        .retry_port     (retry_port),
        .warn_silent    (warn_silent),
        .err_foreign    (err_foreign),
        .overflow       (overflow)
    );

    function automatic bit m_has(input int p);
        for (int i = 0; i < mn; i++) if (mq[i] == p) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void m_pop();
        for (int i = 0; i < DP - 1; i++) mq[i] = mq[i+1];
        if (mn > 0) mn--;
    endfunction

    function automatic void m_reset();
        mn = 0; m_offer = 0; m_rport = 0; m_warn = 0; m_err = 0; m_ovf = 0;
        for (int i = 0; i < DP; i++) mq[i] = 0;
    endfunction

    function automatic void m_step(input bit sv, input int sp, input bit ok,
                                   input bit pd, input bit bf);
        if (!m_offer) begin
            int n0 = mn;
            if (sv && !ok && !pd && !m_has(sp)) begin
                if (mn == DP) m_ovf = 1;
                else begin mq[mn] = sp; mn++; end
            end
            if (bf && n0 > 0) begin m_offer = 1; m_rport = mq[0]; end
        end else begin
            if (sv && sp == m_rport) begin
                if (ok || pd) m_pop();
            end else begin
                m_pop();
                m_warn = 1;
                if (sv) m_err = 1;
            end
            m_offer = 0;
        end
    endfunction

    task automatic step(input bit sv, input int sp, input bit ok, input bit pd, input bit bf);
        @(negedge clk);
        send_valid = sv; send_port = IW'(sp); send_ok = ok;
        send_peer_done = pd; bus_free = bf;
        m_step(sv, sp, ok, pd, bf);
        @(posedge clk);
        #1;
    endtask

    task automatic idle_step();
        step(0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; send_valid = 0; send_ok = 0; send_peer_done = 0; bus_free = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    task automatic chk(input string req);
        logic [NP-1:0] eg;
        eg = m_offer ? (NP'(1) << m_rport) : '0;
        checks++;
        if (retry_gnt !== eg || retry_active !== m_offer ||
            retry_port !== IW'(m_offer ? m_rport : 0) ||
            warn_silent !== m_warn || err_foreign !== m_err || overflow !== m_ovf) begin
            errors++;
            $display("FAIL %s: actual gnt=%b act=%b port=%0d w=%b e=%b o=%b expected gnt=%b act=%b port=%0d w=%b e=%b o=%b",
                     req, retry_gnt, retry_active, retry_port, warn_silent, err_foreign, overflow,
                     eg, m_offer, m_offer ? m_rport : 0, m_warn, m_err, m_ovf);
        end
    endtask

    task automatic chk_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20061009));
        m_reset();

        // R1 reset state
        do_reset();
        chk("R1 reset");
        chk_val("R1 gnt", int'(retry_gnt), 0);

        // R2 tail order, R3 grant, R4 pop on success
        step(1, 5, 0, 0, 0);
        step(1, 2, 0, 0, 0);
        step(1, 6, 0, 0, 0);
        chk("R2 queued, no grant");
        step(0, 0, 0, 0, 1);
        chk("R3 grant");
        chk_val("R3 gnt onehot port 5", int'(retry_gnt), 32);
        step(1, 5, 1, 0, 0);
        chk("R4 pop");
        step(0, 0, 0, 0, 1);
        chk_val("R2 order second", int'(retry_port), 2);
        // R5 refused again keeps head
        step(1, 2, 0, 0, 0);
        chk("R5 back to idle");
        step(0, 0, 0, 0, 1);
        chk_val("R5 same head", int'(retry_port), 2);
        // R6 silent drop
        idle_step();
        chk_val("R6 warn", int'(warn_silent), 1);
        step(0, 0, 0, 0, 1);
        chk_val("R6 next head", int'(retry_port), 6);
        // R7 foreign send
        step(1, 3, 0, 0, 0);
        chk_val("R7 err", int'(err_foreign), 1);
        step(0, 0, 0, 0, 1);
        chk_val("R7 R11 empty queue no grant", int'(retry_active), 0);
        chk("R7 state");

        // R8 peer completion
        do_reset();
        step(1, 1, 0, 0, 0);
        step(1, 4, 0, 1, 0);
        step(0, 0, 0, 0, 1);
        chk_val("R8 grant port 1", int'(retry_port), 1);
        step(1, 1, 0, 1, 0);
        step(0, 0, 0, 0, 1);
        chk_val("R8 popped, 4 not queued", int'(retry_active), 0);
        chk("R8 state");

        // R9 no duplicate
        do_reset();
        step(1, 3, 0, 0, 0);
        step(1, 3, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(1, 3, 1, 0, 0);
        step(0, 0, 0, 0, 1);
        chk_val("R9 single entry", int'(retry_active), 0);

        // R10 overflow
        do_reset();
        for (int p = 0; p < 5; p++) step(1, p, 0, 0, 0);
        chk_val("R10 overflow", int'(overflow), 1);
        for (int p = 0; p < 4; p++) begin
            step(0, 0, 0, 0, 1);
            chk_val("R10 drain order", int'(retry_port), p);
            step(1, p, 1, 0, 0);
        end
        step(0, 0, 0, 0, 1);
        chk_val("R10 port 4 dropped", int'(retry_active), 0);

        // R11 bus_free during offer
        do_reset();
        step(1, 7, 0, 0, 0);
        step(1, 6, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(1, 7, 1, 0, 1);
        chk_val("R11 ignored in offer", int'(retry_active), 0);
        chk("R11 state");

        // Random mix against the model
        do_reset();
        for (int c = 0; c < 6000; c++) begin
            if (c % 500 == 499) do_reset();
            if (m_offer) begin
                int r = int'($urandom_range(0, 9));
                if (r <= 3)      step(1, m_rport, 1, 0, int'($urandom_range(0, 1)));
                else if (r <= 5) step(1, m_rport, 0, 0, 0);
                else if (r == 6) step(1, m_rport, 0, 1, 0);
                else if (r <= 8) idle_step();
                else             step(1, (m_rport + 1) % NP, 0, 0, 0);
            end else begin
                step(int'($urandom_range(0, 2)) == 0, int'($urandom_range(0, NP - 1)),
                     int'($urandom_range(0, 2)) == 0, int'($urandom_range(0, 7)) == 0,
                     int'($urandom_range(0, 3)) == 0);
            end
            chk("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule